// File: doc/BRIEF.md
# Serial Receive FIFO with Status Flags

This block is the receive half of an asynchronous serial port as seen by a CPU. It oversamples the incoming line at 16 times the bit rate and rejects short low pulses that do not last until the middle of a start bit. Each accepted frame is turned into a byte, which goes into a 16-entry receive FIFO. Parity errors, framing errors, line breaks, overruns and idle timeouts are recorded in two small status registers. Software polls the status, reads bytes out of the FIFO, reads the current fill level and writes the control register. The control register holds the receive enable, the trigger level selector and the parity settings.

All status flags use the same clear handshake. Software reads a register while a flag shows 1 and then writes 0 to that bit. A write of 0 without that earlier read does nothing, so a flag that rises between the poll and the write is not lost. The CPU bus is a plain single-cycle strobe interface with no back-pressure. Reads return data combinationally in the same cycle as the strobe. The serial side has no flow control either: a byte that arrives while the FIFO is full is dropped and recorded as a receive error.

Register map on `bus_addr`:
- 0: receive data (read pops).
- 1: status A, with bit0 = trigger reached, bit1 = parity error, bit2 = framing error.
- 2: status B, with bit0 = data ready, bit1 = receive error (overrun), bit2 = break.
- 3: fill level.
- 4: control, with bit0 = enable, bits 2:1 = trigger select, bit3 = parity on, bit4 = odd parity.

Top module: `uart_rx_fifo_stat`

## Requirements
- R1: After reset, status A, status B, the fill level and the control register all read 0.
- R2: A frame is a low start bit, 8 data bits sent LSB first, an optional parity bit and a high stop bit. Each received frame adds its byte to the FIFO and raises the fill level by one.
- R3: A read of address 0 returns the oldest byte and lowers the fill level by one in the same clock edge. A read while the FIFO is empty returns the last byte popped and leaves the level at 0.
- R4: Trigger select 00, 01, 10 and 11 means 1, 4, 8 and 14 bytes. Status A bit0 is set whenever the fill level is at or above the selected count.
- R5: A write of 0 to a status bit clears it only if that register was read while the bit was 1. A write of 0 without that read leaves the bit at 1.
- R6: When parity is on, the parity bit makes the count of ones over data and parity even (bit4 = 0) or odd (bit4 = 1). A mismatch sets status A bit1.
- R7: A stop bit sampled low sets status A bit2, and the byte is still stored.
- R8: A framing error with all data bits and the parity bit low is a break. It sets status B bit2, nothing is stored, and reception resumes only after the line returns high.
- R9: A byte that completes while 16 bytes are held is discarded, status B bit1 is set, and the held bytes are unchanged.
- R10: If the line has been idle for 15 bit times while the FIFO holds at least one byte but fewer than the trigger count, status B bit0 is set.
- R11: While control bit0 is 0, the receiver ignores the line: no byte is stored and no flag changes.
- R12: A low pulse on the line that is high again at the middle of the start bit is dropped, and a later frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |

## Verification
A wrong FIFO pointer or count shows up within one frame time, as a fill level that differs from the number of bytes sent or as bytes read back out of order. A fault in the flag arming latch shows up on the very next status read, as a flag that clears without a prior read or does not clear after one. A mistimed bit counter in the deserializer corrupts the first byte sent or raises false framing and parity errors. The idle timer and the glitch filter are checked in time windows a few hundred clocks either side of their thresholds.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int OSR = 16;
  localparam int DW  = 8;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_STA  = 3'd1;
  localparam logic [2:0] A_STB  = 3'd2;
  localparam logic [2:0] A_LVL  = 3'd3;
  localparam logic [2:0] A_CTL  = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          perr;
    logic          ferr;
    logic          brk;
  } rx_frame_t;
endpackage

// File: rtl/urx_deser.sv
module urx_deser import urx_pkg::*; #(
  parameter int TICK_DIV = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rxd,
  input  logic      en,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      busy,
  output logic      tick_o,
  output logic      frm_valid,
  output rx_frame_t frm
);
  localparam int DIVW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNTW = $clog2(OSR);
  localparam logic [CNTW-1:0] MID_C  = CNTW'(OSR/2 - 1);
  localparam logic [CNTW-1:0] LAST_C = CNTW'(OSR - 1);
  localparam logic [DIVW-1:0] DIV_END = DIVW'(TICK_DIV - 1);

  logic            sync1, rx_s;
  logic [DIVW-1:0] div_q;
  logic            tick;
  rx_state_e       state;
  logic [CNTW-1:0] cnt;
  logic [2:0]      nbits;
  logic [DW-1:0]   shreg;
  logic            par_bit;

  // two-flop synchroniser, idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      sync1 <= rxd;
      rx_s  <= sync1;
    end
  end

  // oversampling tick divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_q == DIV_END) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end
  assign tick   = (div_q == DIV_END);
  assign tick_o = tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      nbits     <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      frm_valid <= 1'b0;
      frm       <= '0;
    end else begin
      frm_valid <= 1'b0;
      if (!en) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        case (state)
          S_IDLE: begin
            cnt <= '0;
            if (!rx_s) state <= S_START;
          end
          S_START: begin
            if (cnt == MID_C) begin
              cnt   <= '0;
              nbits <= '0;
              state <= rx_s ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == LAST_C) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[DW-1:1]};
              nbits <= nbits + 1'b1;
              if (nbits == 3'd7) state <= par_en ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == LAST_C) begin
              cnt     <= '0;
              par_bit <= rx_s;
              state   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST_C) begin
              cnt       <= '0;
              frm_valid <= 1'b1;
              frm.data  <= shreg;
              frm.perr  <= par_en && ((^shreg ^ par_bit) != par_odd);
              frm.ferr  <= !rx_s;
              frm.brk   <= !rx_s && (shreg == '0) && (!par_en || !par_bit);
              state     <= rx_s ? S_IDLE : S_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_HOLD: if (rx_s) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign busy = (state != S_IDLE);

  // R11
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !frm_valid);

  // R2
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf
);
  localparam logic [AW-1:0] PTR_END = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ovf     = push && full;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_END) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_END) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CNT_MAX));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/urx_flag.sv
module urx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic arm_q;
  logic clr;

  assign clr = wr_i && !wbit_i && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)    flag_o <= 1'b1;
      else if (clr) flag_o <= 1'b0;
      if (clr)                  arm_q <= 1'b0;
      else if (rd_i && flag_o)  arm_q <= 1'b1;
    end
  end

  // R5
  clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wbit_i && !arm_q && flag_o) |=> flag_o);

  // R5
  clear_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wbit_i && arm_q && !set_i) |=> !flag_o);
endmodule

// File: rtl/uart_rx_fifo_stat.sv
module uart_rx_fifo_stat import urx_pkg::*; #(
  parameter int TICK_DIV = 4,
  parameter int DEPTH    = 16,
  parameter int IDLE_ETU = 15,
  parameter int TRIG_L0  = 1,
  parameter int TRIG_L1  = 4,
  parameter int TRIG_L2  = 8,
  parameter int TRIG_L3  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int IDLE_T  = IDLE_ETU * OSR;
  localparam int IW      = $clog2(IDLE_T + 1);
  localparam int NFLAG   = 6;
  localparam int PERREG  = 3;
  localparam logic [IW-1:0] IDLE_END = IW'(IDLE_T);
  localparam logic [IW-1:0] IDLE_PRE = IW'(IDLE_T - 1);

  // control register
  logic       rx_en, par_en, par_odd;
  logic [1:0] trig_sel;

  // datapath
  logic          busy, tick, frm_valid;
  rx_frame_t     frm;
  logic          push, pop;
  logic [DW-1:0] head, last_q;
  logic [CW-1:0] count, trig_lvl;
  logic          full, empty, ovf;
  logic [IW-1:0] idle_q;
  logic          idle_hit;
  logic [NFLAG-1:0] flag_set, flag_q;
  logic [2:0]    wire_unused;

  assign wire_unused = bus_wdata[7:5];

  urx_deser #(.TICK_DIV(TICK_DIV)) u_deser (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .en(rx_en),
    .par_en(par_en), .par_odd(par_odd), .busy(busy), .tick_o(tick),
    .frm_valid(frm_valid), .frm(frm)
  );

  assign push = frm_valid && !frm.brk;
  assign pop  = bus_rd && (bus_addr == A_DATA);

  urx_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(frm.data), .pop(pop),
    .head(head), .count(count), .full(full), .empty(empty), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      trig_sel <= 2'b00;
      par_en   <= 1'b0;
      par_odd  <= 1'b0;
    end else if (bus_wr && bus_addr == A_CTL) begin
      rx_en    <= bus_wdata[0];
      trig_sel <= bus_wdata[2:1];
      par_en   <= bus_wdata[3];
      par_odd  <= bus_wdata[4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               last_q <= '0;
    else if (pop && !empty)   last_q <= head;
  end

  always_comb begin
    case (trig_sel)
      2'b00:   trig_lvl = CW'(TRIG_L0);
      2'b01:   trig_lvl = CW'(TRIG_L1);
      2'b10:   trig_lvl = CW'(TRIG_L2);
      default: trig_lvl = CW'(TRIG_L3);
    endcase
  end

  // idle timer in oversampling ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idle_q <= '0;
    else if (busy || !rx_en)             idle_q <= '0;
    else if (tick && idle_q != IDLE_END) idle_q <= idle_q + 1'b1;
  end
  assign idle_hit = tick && rx_en && !busy && (idle_q == IDLE_PRE);

  assign flag_set[0] = (count >= trig_lvl);
  assign flag_set[1] = frm_valid && frm.perr;
  assign flag_set[2] = frm_valid && frm.ferr;
  assign flag_set[3] = idle_hit && !empty && (count < trig_lvl);
  assign flag_set[4] = ovf;
  assign flag_set[5] = frm_valid && frm.brk;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam logic [2:0] REG_A = (i < PERREG) ? A_STA : A_STB;
    localparam int         BITP  = i % PERREG;
    urx_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set[i]),
      .rd_i(bus_rd && bus_addr == REG_A),
      .wr_i(bus_wr && bus_addr == REG_A),
      .wbit_i(bus_wdata[BITP]),
      .flag_o(flag_q[i])
    );
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = empty ? last_q : head;
      A_STA:   bus_rdata = {5'b0, flag_q[2:0]};
      A_STB:   bus_rdata = {5'b0, flag_q[5:3]};
      A_LVL:   bus_rdata = 8'(count);
      A_CTL:   bus_rdata = {3'b0, par_odd, par_en, trig_sel, rx_en};
      default: bus_rdata = 8'h00;
    endcase
  end

  // R4
  rdf_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= trig_lvl) |=> flag_q[0]);

  // R3
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1));

  // R8
  brk_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm.brk && !pop) |=> $stable(count));
endmodule

// File: tb/tb_uart_rx_fifo_stat.sv
module tb_uart_rx_fifo_stat;
  localparam int DIV = 4;
  localparam int BT  = DIV * 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int tests = 0, fails = 0;
  bit done = 0;
  byte unsigned q[$];
  byte unsigned last_b = 0;

  always #2 clk = ~clk;

  uart_rx_fifo_stat #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic par_of(input logic [7:0] b, input bit odd);
    return (^b) ^ odd;
  endfunction

  function automatic logic [7:0] ctl(input bit en, input logic [1:0] sel,
                                     input bit pen, input bit odd);
    return {3'b0, odd, pen, sel, en};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    @(negedge clk);
    rxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit pen, input bit odd,
                      input bit badpar, input logic stopv);
    hold(1'b0, BT);
    for (int i = 0; i < 8; i++) hold(b[i], BT);
    if (pen) hold(par_of(b, odd) ^ badpar, BT);
    hold(stopv, BT);
    if (!stopv) hold(1'b1, BT);
    @(negedge clk);
    rxd = 1'b1;
  endtask

  // model-side push: count bounded by 16
  task automatic sendq(input logic [7:0] b, input bit pen, input bit odd);
    send(b, pen, odd, 1'b0, 1'b1);
    if (q.size() < 16) q.push_back(b);
  endtask

  task automatic drain(input string req);
    logic [7:0] d;
    while (q.size() > 0) begin
      rd(3'd3, d);
      chk(req, d, 8'(q.size()));
      rd(3'd0, d);
      last_b = q.pop_front();
      chk(req, d, last_b);
    end
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rd(3'd1, d); wr(3'd1, 8'h00);
    rd(3'd2, d); wr(3'd2, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int lv [4] = '{1, 4, 8, 14};
    void'($urandom(32'd7411));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(3'd1, d); chk("R1 statA", d, 8'h00);
    rd(3'd2, d); chk("R1 statB", d, 8'h00);
    rd(3'd3, d); chk("R1 level", d, 8'h00);
    rd(3'd4, d); chk("R1 ctrl", d, 8'h00);

    // R2 random bytes, no parity, trigger 14
    wr(3'd4, ctl(1, 2'b11, 0, 0));
    for (int k = 0; k < 6; k++) begin
      sendq(8'($urandom), 0, 0);
      rd(3'd3, d); chk("R2 level", d, 8'(q.size()));
    end
    drain("R3 pop order");
    // R3 empty read
    rd(3'd0, d); chk("R3 empty data", d, last_b);
    rd(3'd3, d); chk("R3 empty level", d, 8'h00);

    // R4 trigger levels, R5 clear after read
    for (int s = 0; s < 4; s++) begin
      wr(3'd4, ctl(1, 2'(s), 0, 0));
      clear_all();
      for (int k = 1; k <= lv[s]; k++) begin
        sendq(8'($urandom), 0, 0);
        if (k == lv[s] - 1) begin
          rd(3'd1, d); chk("R4 below trigger", d & 8'h01, 8'h00);
        end
        if (k == lv[s]) begin
          rd(3'd1, d); chk("R4 at trigger", d & 8'h01, 8'h01);
        end
      end
      drain("R4 drain");
      wr(3'd1, 8'h00);
      rd(3'd1, d); chk("R5 cleared after read", d & 8'h01, 8'h00);
    end

    // R6 parity, R5 write without read
    clear_all();
    wr(3'd4, ctl(1, 2'b11, 1, 0));
    sendq(8'h5A, 1, 0);
    rd(3'd1, d); chk("R6 even ok", d, 8'h00);
    wr(3'd4, ctl(1, 2'b11, 1, 1));
    sendq(8'h5B, 1, 1);
    rd(3'd1, d); chk("R6 odd ok", d, 8'h00);
    send(8'h33, 1, 1, 1'b1, 1'b1); q.push_back(8'h33);
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R5 no-read write keeps / R6 perr", d, 8'h02);
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R5 clear after read", d, 8'h00);
    drain("R6 drain");

    // R7 framing error keeps byte
    wr(3'd4, ctl(1, 2'b11, 0, 0));
    send(8'hA5, 0, 0, 1'b0, 1'b0); q.push_back(8'hA5);
    rd(3'd1, d); chk("R7 ferr", d, 8'h04);
    rd(3'd3, d); chk("R7 level", d, 8'h01);
    drain("R7 data");
    clear_all();

    // R8 break
    hold(1'b0, 12 * BT);
    hold(1'b1, 2 * BT);
    rd(3'd2, d); chk("R8 break flag", d & 8'h04, 8'h04);
    rd(3'd3, d); chk("R8 not stored", d, 8'h00);
    clear_all();
    sendq(8'hC3, 0, 0);
    drain("R8 resumes");

    // R9 overrun
    clear_all();
    for (int k = 0; k < 16; k++) sendq(8'($urandom), 0, 0);
    send(8'hEE, 0, 0, 1'b0, 1'b1);
    rd(3'd2, d); chk("R9 overrun flag", d & 8'h02, 8'h02);
    rd(3'd3, d); chk("R9 level", d, 8'd16);
    drain("R9 contents");
    clear_all();

    // R10 idle timeout
    clear_all();
    sendq(8'h11, 0, 0);
    sendq(8'h22, 0, 0);
    repeat (800) @(negedge clk);
    rd(3'd2, d); chk("R10 before timeout", d & 8'h01, 8'h00);
    repeat (250) @(negedge clk);
    rd(3'd2, d); chk("R10 after timeout", d & 8'h01, 8'h01);
    drain("R10 drain");
    clear_all();

    // R11 receiver disabled
    wr(3'd4, ctl(0, 2'b11, 0, 0));
    send(8'h81, 0, 0, 1'b0, 1'b0);
    rd(3'd3, d); chk("R11 level", d, 8'h00);
    rd(3'd1, d); chk("R11 flags", d, 8'h00);

    // R12 glitch rejection
    wr(3'd4, ctl(1, 2'b11, 0, 0));
    hold(1'b0, 16);
    hold(1'b1, 2 * BT);
    rd(3'd3, d); chk("R12 glitch level", d, 8'h00);
    rd(3'd1, d); chk("R12 glitch flags", d, 8'h00);
    sendq(8'h3C, 0, 0);
    drain("R12 after glitch");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule